// File: doc/BRIEF.md
# Priority-Level Interrupt Acceptance Unit

This block sits between a set of peripheral interrupt sources and a processor core. It decides whether a pending request may be accepted, and which one wins. Each source has a pending latch and a priority field. A peripheral event pulse sets the latch. Software reads and writes the latch and the field through a small indexed configuration port.

The core supplies two inputs: a global maskable-interrupt enable and its current priority level. A source qualifies only when all three of these hold:
- the enable is high;
- its pending latch is set;
- its priority is strictly above the core level.

Among the qualifying sources, the highest priority wins. When priorities tie, the lowest index wins.

The decision is registered. The acceptance strobe, the winner's index and the winner's priority appear one cycle after the state they were derived from. The strobe is a single-cycle pulse. On the clock edge that ends the pulse, the winner's pending latch is cleared, and the core can load the accepted priority as its new level. The arbiter is built either as a linear scan or as a balanced comparison tree, chosen by a parameter.

Top module: `prio_ack_unit`

## Requirements
- R1: After reset every pending latch and every priority field read back as 0, and `ack_o` is 0.
- R2: `ack_o` rises in the cycle after one in which `core_ien_i` was 1, the pending latch of some source was 1 and that source's priority was strictly greater than `core_cpl_i`. Alongside it, `ack_idx_o` and `ack_lvl_o` give that source's index and its priority from that cycle.
- R3: When `core_cpl_i` is 7 (all ones), `ack_o` is 0 in the following cycle whatever the source priorities are.
- R4: A source whose priority field is 0 is never accepted.
- R5: Among qualifying sources, the one with the numerically highest priority wins. Among equal priorities, the lowest index wins.
- R6: A 1 on `src_evt_i[i]` sets pending latch i at the next edge. The latch then stays 1 until it is accepted or written to 0.
- R7: With `cfg_pend_we_i` high, `cfg_pend_i` is written into the latch selected by `cfg_idx_i`. If an event for that source arrives in the same cycle, the latch ends up 1.
- R8: `ack_o` is never high in two consecutive cycles. At the edge that ends an acceptance pulse, the winner's pending latch is cleared, unless an event or a software write of 1 hits it in that same cycle.
- R9: `cfg_lvl_we_i` writes `cfg_lvl_i` into the selected priority field and leaves every pending latch unchanged. A pending write leaves every priority field unchanged. The peek port returns the latch and field of `peek_idx_i` combinationally.
- R10: While `core_ien_i` is 0, `ack_o` is 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_evt_i | input | N_SRC | Per-source event pulses that set the pending latches |
| cfg_idx_i | input | IDX_W | Source selected for a configuration write |
| cfg_pend_we_i | input | 1 | Write enable for the selected pending latch |
| cfg_pend_i | input | 1 | Value written to the pending latch |
| cfg_lvl_we_i | input | 1 | Write enable for the selected priority field |
| cfg_lvl_i | input | LVL_W | Value written to the priority field |
| peek_idx_i | input | IDX_W | Source selected for read-back |
| peek_pend_o | output | 1 | Pending latch of the selected source |
| peek_lvl_o | output | LVL_W | Priority field of the selected source |
| core_ien_i | input | 1 | Global maskable-interrupt enable from the core |
| core_cpl_i | input | LVL_W | Current core priority level |
| ack_o | output | 1 | One-cycle acceptance strobe |
| ack_idx_o | output | IDX_W | Index of the accepted source |
| ack_lvl_o | output | LVL_W | Priority of the accepted source |

## Verification
Configuration writes and event pulses change the latches and fields at the next edge, and the peek port shows the new values in the same cycle, so read-backs are sampled on the falling edge right after the write edge. The acceptance strobe is due one edge later than the state that produced it: two edges after a write or an event, and one edge after a change of `core_ien_i` or `core_cpl_i`. The clearing of the winner's latch is visible one edge after the strobe. The bench drives inputs on falling edges and steps a cycle model through the same edges, so every comparison is made at the falling edge that follows the edge that must produce it. Random traffic is checked against that model on every cycle, and hand-timed directed cases cover masking, ties, zero priority and the set-versus-clear race.

// File: rtl/irq_ack_pkg.sv
package irq_ack_pkg;

   // Index width for a population of n sources (never below one bit).
   function automatic int idx_bits(input int n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

   // Arbiter structure selectors.
   localparam bit ARB_LINEAR = 1'b0;
   localparam bit ARB_TREE   = 1'b1;

endpackage

// File: rtl/irq_src_bank.sv
module irq_src_bank #(
   parameter int N_SRC = 8,
   parameter int LVL_W = 3,
   parameter int IDX_W = 3
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [N_SRC-1:0]              evt_i,
   input  logic [IDX_W-1:0]              wr_idx_i,
   input  logic                          wr_pend_en_i,
   input  logic                          wr_pend_i,
   input  logic                          wr_lvl_en_i,
   input  logic [LVL_W-1:0]              wr_lvl_i,
   input  logic                          clr_en_i,
   input  logic [IDX_W-1:0]              clr_idx_i,
   input  logic                          ien_i,
   input  logic [LVL_W-1:0]              cpl_i,
   output logic [N_SRC-1:0]              pend_o,
   output logic [N_SRC-1:0][LVL_W-1:0]   lvl_o,
   output logic [N_SRC-1:0]              qual_o
);

   for (genvar i = 0; i < N_SRC; i++) begin : g_src
      localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(i);

      logic sel_w;
      logic clr_w;
      logic pend_q;
      logic pend_d;
      logic [LVL_W-1:0] lvl_q;

      assign sel_w = (wr_idx_i == MY_IDX);
      assign clr_w = clr_en_i && (clr_idx_i == MY_IDX);

      // Later assignments take precedence: ack clear, then software, then event.
      always_comb begin
         pend_d = pend_q;
         if (clr_w)
            pend_d = 1'b0;
         if (wr_pend_en_i && sel_w)
            pend_d = wr_pend_i;
         if (evt_i[i])
            pend_d = 1'b1;
      end

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            pend_q <= 1'b0;
            lvl_q  <= '0;
         end else begin
            pend_q <= pend_d;
            if (wr_lvl_en_i && sel_w)
               lvl_q <= wr_lvl_i;
         end
      end

      assign pend_o[i] = pend_q;
      assign lvl_o[i]  = lvl_q;
      assign qual_o[i] = ien_i && pend_q && (lvl_q > cpl_i);
   end

endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb #(
   parameter int N_SRC    = 8,
   parameter int LVL_W    = 3,
   parameter int IDX_W    = 3,
   parameter bit USE_TREE = 1'b0
) (
   input  logic [N_SRC-1:0]              qual_i,
   input  logic [N_SRC-1:0][LVL_W-1:0]   lvl_i,
   output logic                          win_v_o,
   output logic [IDX_W-1:0]              win_idx_o,
   output logic [LVL_W-1:0]              win_lvl_o
);

   if (USE_TREE) begin : g_tree
      localparam int LEAVES = 1 << IDX_W;
      localparam int NODES  = 2 * LEAVES - 1;

      logic             nv [NODES];
      logic [LVL_W-1:0] nl [NODES];
      logic [IDX_W-1:0] ni [NODES];

      for (genvar j = 0; j < LEAVES; j++) begin : g_leaf
         if (j < N_SRC) begin : g_real
            assign nv[LEAVES-1+j] = qual_i[j];
            assign nl[LEAVES-1+j] = lvl_i[j];
            assign ni[LEAVES-1+j] = IDX_W'(j);
         end else begin : g_pad
            assign nv[LEAVES-1+j] = 1'b0;
            assign nl[LEAVES-1+j] = '0;
            assign ni[LEAVES-1+j] = '0;
         end
      end

      // Left child holds lower indices; the right one wins only on a strictly higher level.
      for (genvar k = 0; k < LEAVES - 1; k++) begin : g_node
         logic take_r;
         assign take_r = nv[2*k+2] && (!nv[2*k+1] || (nl[2*k+2] > nl[2*k+1]));
         assign nv[k]  = nv[2*k+1] || nv[2*k+2];
         assign nl[k]  = take_r ? nl[2*k+2] : nl[2*k+1];
         assign ni[k]  = take_r ? ni[2*k+2] : ni[2*k+1];
      end

      assign win_v_o   = nv[0];
      assign win_lvl_o = nl[0];
      assign win_idx_o = ni[0];
   end else begin : g_linear
      always_comb begin
         win_v_o   = 1'b0;
         win_lvl_o = '0;
         win_idx_o = '0;
         for (int i = 0; i < N_SRC; i++) begin
            if (qual_i[i] && (!win_v_o || (lvl_i[i] > win_lvl_o))) begin
               win_v_o   = 1'b1;
               win_lvl_o = lvl_i[i];
               win_idx_o = IDX_W'(i);
            end
         end
      end
   end

endmodule

// File: rtl/prio_ack_unit.sv
module prio_ack_unit #(
   parameter int  N_SRC    = 8,
   parameter int  LVL_W    = 3,
   parameter bit  USE_TREE = irq_ack_pkg::ARB_LINEAR,
   localparam int IDX_W    = irq_ack_pkg::idx_bits(N_SRC)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_SRC-1:0]   src_evt_i,
   input  logic [IDX_W-1:0]   cfg_idx_i,
   input  logic               cfg_pend_we_i,
   input  logic               cfg_pend_i,
   input  logic               cfg_lvl_we_i,
   input  logic [LVL_W-1:0]   cfg_lvl_i,
   input  logic [IDX_W-1:0]   peek_idx_i,
   output logic               peek_pend_o,
   output logic [LVL_W-1:0]   peek_lvl_o,
   input  logic               core_ien_i,
   input  logic [LVL_W-1:0]   core_cpl_i,
   output logic               ack_o,
   output logic [IDX_W-1:0]   ack_idx_o,
   output logic [LVL_W-1:0]   ack_lvl_o
);

   if (N_SRC < 2) begin : g_bad_nsrc
      $error("prio_ack_unit: N_SRC must be at least 2");
   end
   if (LVL_W < 1) begin : g_bad_lvlw
      $error("prio_ack_unit: LVL_W must be at least 1");
   end

   logic [N_SRC-1:0]            src_ir;
   logic [N_SRC-1:0][LVL_W-1:0] src_lvl;
   logic [N_SRC-1:0]            src_qual;
   logic                        win_v;
   logic [IDX_W-1:0]            win_idx;
   logic [LVL_W-1:0]            win_lvl;

   logic                        ack_q;
   logic [IDX_W-1:0]            idx_q;
   logic [LVL_W-1:0]            lvl_q;

   irq_src_bank #(
      .N_SRC (N_SRC),
      .LVL_W (LVL_W),
      .IDX_W (IDX_W)
   ) u_bank (
      .clk          (clk),
      .rst_n        (rst_n),
      .evt_i        (src_evt_i),
      .wr_idx_i     (cfg_idx_i),
      .wr_pend_en_i (cfg_pend_we_i),
      .wr_pend_i    (cfg_pend_i),
      .wr_lvl_en_i  (cfg_lvl_we_i),
      .wr_lvl_i     (cfg_lvl_i),
      .clr_en_i     (ack_q),
      .clr_idx_i    (idx_q),
      .ien_i        (core_ien_i),
      .cpl_i        (core_cpl_i),
      .pend_o       (src_ir),
      .lvl_o        (src_lvl),
      .qual_o       (src_qual)
   );

   irq_prio_arb #(
      .N_SRC    (N_SRC),
      .LVL_W    (LVL_W),
      .IDX_W    (IDX_W),
      .USE_TREE (USE_TREE)
   ) u_arb (
      .qual_i    (src_qual),
      .lvl_i     (src_lvl),
      .win_v_o   (win_v),
      .win_idx_o (win_idx),
      .win_lvl_o (win_lvl)
   );

   // Registered decision; a cycle with ack high cannot start a new one,
   // because the winner's latch is only cleared at the edge ending the pulse.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ack_q <= 1'b0;
         idx_q <= '0;
         lvl_q <= '0;
      end else if (ack_q) begin
         ack_q <= 1'b0;
      end else begin
         ack_q <= win_v;
         if (win_v) begin
            idx_q <= win_idx;
            lvl_q <= win_lvl;
         end
      end
   end

   assign ack_o     = ack_q;
   assign ack_idx_o = idx_q;
   assign ack_lvl_o = lvl_q;

   always_comb begin
      peek_pend_o = 1'b0;
      peek_lvl_o  = '0;
      if (int'(peek_idx_i) < N_SRC) begin
         peek_pend_o = src_ir[peek_idx_i];
         peek_lvl_o  = src_lvl[peek_idx_i];
      end
   end

endmodule

// File: rtl/prio_ack_chk.sv
module prio_ack_chk #(
   parameter int  N_SRC = 8,
   parameter int  LVL_W = 3,
   localparam int IDX_W = irq_ack_pkg::idx_bits(N_SRC)
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic [N_SRC-1:0]            src_evt_i,
   input logic [IDX_W-1:0]            cfg_idx_i,
   input logic                        cfg_pend_we_i,
   input logic                        cfg_pend_i,
   input logic                        core_ien_i,
   input logic [LVL_W-1:0]            core_cpl_i,
   input logic                        ack_o,
   input logic [IDX_W-1:0]            ack_idx_o,
   input logic [LVL_W-1:0]            ack_lvl_o,
   input logic [N_SRC-1:0]            src_ir,
   input logic [N_SRC-1:0][LVL_W-1:0] src_lvl
);

   p_ack_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ack_o |=> !ack_o);

   p_ack_above_cpl_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ack_o |-> (ack_lvl_o > $past(core_cpl_i)) && $past(core_ien_i));

   p_mask_all_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (core_cpl_i == '1) |=> !ack_o);

   p_ien_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !core_ien_i |=> !ack_o);

   p_zero_lvl_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ack_o |-> (ack_lvl_o != '0));

   for (genvar i = 0; i < N_SRC; i++) begin : g_src
      localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(i);

      p_evt_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
         src_evt_i[i] |=> src_ir[i]);

      p_pend_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (src_ir[i] && !(ack_o && ack_idx_o == MY_IDX)
          && !(cfg_pend_we_i && cfg_idx_i == MY_IDX)) |=> src_ir[i]);

      p_ack_from_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
         (ack_o && ack_idx_o == MY_IDX) |->
            ($past(src_ir[i]) && ack_lvl_o == $past(src_lvl[i])));

      p_ack_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (ack_o && ack_idx_o == MY_IDX && !src_evt_i[i]
          && !(cfg_pend_we_i && cfg_pend_i && cfg_idx_i == MY_IDX)) |=> !src_ir[i]);
   end

endmodule

bind prio_ack_unit prio_ack_chk #(
   .N_SRC (N_SRC),
   .LVL_W (LVL_W)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .src_evt_i     (src_evt_i),
   .cfg_idx_i     (cfg_idx_i),
   .cfg_pend_we_i (cfg_pend_we_i),
   .cfg_pend_i    (cfg_pend_i),
   .core_ien_i    (core_ien_i),
   .core_cpl_i    (core_cpl_i),
   .ack_o         (ack_o),
   .ack_idx_o     (ack_idx_o),
   .ack_lvl_o     (ack_lvl_o),
   .src_ir        (src_ir),
   .src_lvl       (src_lvl)
);

// File: tb/test_prio_ack_unit.sv
module test_prio_ack_unit;

   localparam int  N     = 8;
   localparam int  LW    = 3;
   localparam int  IW    = 3;
   localparam time T_CLK = 10ns;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  src_evt = '0;
   logic [IW-1:0] cfg_idx = '0;
   logic          cfg_pend_we = 1'b0;
   logic          cfg_pend = 1'b0;
   logic          cfg_lvl_we = 1'b0;
   logic [LW-1:0] cfg_lvl = '0;
   logic [IW-1:0] peek_idx = '0;
   logic          peek_pend;
   logic [LW-1:0] peek_lvl;
   logic          ien = 1'b0;
   logic [LW-1:0] cpl = '0;
   logic          ack;
   logic [IW-1:0] ack_idx;
   logic [LW-1:0] ack_lvl;

   int n_run = 0;
   int n_fail = 0;

   // Cycle model state
   bit          m_ir [N];
   bit [LW-1:0] m_lv [N];
   bit          m_ack;
   bit [IW-1:0] m_idx;
   bit [LW-1:0] m_lvl;

   always #(T_CLK/2) clk = ~clk;

   prio_ack_unit #(.N_SRC(N), .LVL_W(LW)) i_prio_ack_unit (
      .clk           (clk),
      .rst_n         (rst_n),
      .src_evt_i     (src_evt),
      .cfg_idx_i     (cfg_idx),
      .cfg_pend_we_i (cfg_pend_we),
      .cfg_pend_i    (cfg_pend),
      .cfg_lvl_we_i  (cfg_lvl_we),
      .cfg_lvl_i     (cfg_lvl),
      .peek_idx_i    (peek_idx),
      .peek_pend_o   (peek_pend),
      .peek_lvl_o    (peek_lvl),
      .core_ien_i    (ien),
      .core_cpl_i    (cpl),
      .ack_o         (ack),
      .ack_idx_o     (ack_idx),
      .ack_lvl_o     (ack_lvl)
   );

   task automatic check(input string req, input int got, input int exp);
      n_run++;
      if (got != exp) begin
         n_fail++;
         $display("[TB] FAIL %s: got %0d expected %0d", req, got, exp);
      end
   endtask

   // Winner by requirement: strict level above cpl, highest level, lowest index.
   function automatic int pick_winner(output bit [LW-1:0] wl);
      int w = -1;
      wl = '0;
      if (!ien) return -1;
      for (int i = 0; i < N; i++)
         if (m_ir[i] && m_lv[i] > cpl && (w < 0 || m_lv[i] > wl)) begin
            w  = i;
            wl = m_lv[i];
         end
      return w;
   endfunction

   // One clock: advance the model over the edge, then compare at the falling edge.
   task automatic tick();
      bit [LW-1:0] wl;
      int w;
      bit n_ack;
      bit n_ir [N];
      w = pick_winner(wl);
      n_ack = !m_ack && (w >= 0);
      for (int i = 0; i < N; i++) begin
         n_ir[i] = m_ir[i];
         if (m_ack && m_idx == IW'(i)) n_ir[i] = 1'b0;
         if (cfg_pend_we && cfg_idx == IW'(i)) n_ir[i] = cfg_pend;
         if (src_evt[i]) n_ir[i] = 1'b1;
      end
      if (cfg_lvl_we) m_lv[cfg_idx] = cfg_lvl;
      for (int i = 0; i < N; i++) m_ir[i] = n_ir[i];
      if (n_ack) begin
         m_idx = IW'(w);
         m_lvl = wl;
      end
      m_ack = n_ack;
      @(posedge clk);
      @(negedge clk);
      check("R2 R8 ack strobe", int'(ack), int'(m_ack));
      if (m_ack && ack) begin
         check("R5 winner index", int'(ack_idx), int'(m_idx));
         check("R2 winner level", int'(ack_lvl), int'(m_lvl));
      end
   endtask

   task automatic quiet();
      src_evt = '0;
      cfg_pend_we = 1'b0;
      cfg_lvl_we = 1'b0;
   endtask

   task automatic set_lvl(input int s, input int v);
      cfg_idx = IW'(s); cfg_lvl = LW'(v); cfg_lvl_we = 1'b1;
      tick(); quiet();
   endtask

   task automatic set_pend(input int s, input bit v);
      cfg_idx = IW'(s); cfg_pend = v; cfg_pend_we = 1'b1;
      tick(); quiet();
   endtask

   task automatic peek(input int s, output bit p, output int l);
      peek_idx = IW'(s);
      #1;
      p = peek_pend;
      l = int'(peek_lvl);
   endtask

   initial begin
      bit p;
      int l;
      void'($urandom(32'd20240611));
      for (int i = 0; i < N; i++) begin m_ir[i] = 0; m_lv[i] = 0; end
      m_ack = 0; m_idx = 0; m_lvl = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      check("R1 ack after reset", int'(ack), 0);
      for (int i = 0; i < N; i++) begin
         peek(i, p, l);
         check("R1 pending after reset", int'(p), 0);
         check("R1 level after reset", l, 0);
      end

      // R9: writes are independent
      set_lvl(3, 5);
      peek(3, p, l);
      check("R9 level write leaves pending", int'(p), 0);
      check("R9 level written", l, 5);
      set_pend(3, 1'b1);
      peek(3, p, l);
      check("R9 pending write leaves level", l, 5);
      check("R9 pending written", int'(p), 1);

      // R10: enable low blocks
      ien = 1'b0; cpl = 3'd0;
      tick(); tick();
      check("R10 no ack while disabled", int'(ack), 0);

      // R3: cpl 7 masks everything
      ien = 1'b1; cpl = 3'd7;
      tick(); tick();
      check("R3 no ack at cpl 7", int'(ack), 0);
      cpl = 3'd5;
      tick(); tick();
      check("R2 equal level not accepted", int'(ack), 0);
      cpl = 3'd4;
      tick();
      check("R2 ack one cycle after cpl drop", int'(ack), 1);
      check("R2 ack index", int'(ack_idx), 3);
      check("R2 ack level", int'(ack_lvl), 5);
      tick();
      check("R8 ack is one pulse", int'(ack), 0);
      peek(3, p, l);
      check("R8 pending cleared after ack", int'(p), 0);

      // R4: level 0 never accepted
      cpl = 3'd0;
      set_pend(1, 1'b1);
      tick(); tick();
      check("R4 zero level ignored", int'(ack), 0);
      set_pend(1, 1'b0);

      // R5: tie goes to lowest index, then the other follows
      ien = 1'b0;
      set_lvl(2, 4); set_lvl(6, 4);
      set_pend(6, 1'b1); set_pend(2, 1'b1);
      ien = 1'b1;
      tick();
      check("R5 tie lowest index", int'(ack_idx), 2);
      tick(); tick();
      check("R5 second of tie", int'(ack_idx), 6);
      tick();

      // R5: higher level beats lower index
      ien = 1'b0;
      set_lvl(0, 3); set_lvl(5, 6);
      set_pend(0, 1'b1); set_pend(5, 1'b1);
      ien = 1'b1;
      tick();
      check("R5 highest level wins", int'(ack_idx), 5);
      tick(); tick(); tick();
      ien = 1'b0;

      // R7: event beats software clear in the same cycle
      cfg_idx = 3'd4; cfg_pend = 1'b0; cfg_pend_we = 1'b1; src_evt = 8'h10;
      tick(); quiet();
      peek(4, p, l);
      check("R7 set wins over clear", int'(p), 1);
      set_pend(4, 1'b0);
      peek(4, p, l);
      check("R7 software clear", int'(p), 0);

      // R6: event sets and holds while masked
      src_evt = 8'h80;
      tick(); quiet();
      repeat (5) tick();
      peek(7, p, l);
      check("R6 event latched and held", int'(p), 1);
      set_pend(7, 1'b0);

      // Random traffic checked every cycle against the model (R2 R5 R6 R7 R8)
      for (int c = 0; c < 3000; c++) begin
         for (int i = 0; i < N; i++) src_evt[i] = ($urandom % 20) == 0;
         cfg_pend_we = ($urandom % 8) == 0;
         cfg_lvl_we  = ($urandom % 6) == 0;
         cfg_idx     = IW'($urandom);
         cfg_pend    = 1'($urandom);
         cfg_lvl     = LW'($urandom);
         if (($urandom % 10) == 0) ien = ($urandom % 8) != 0;
         if (($urandom % 7) == 0) cpl = LW'($urandom);
         tick();
         if ((c % 50) == 0) begin
            int s = int'($urandom % N);
            quiet();
            peek(s, p, l);
            check("R6 R7 pending readback", int'(p), int'(m_ir[s]));
            check("R9 level readback", l, int'(m_lv[s]));
         end
      end
      quiet();

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_run++;
      n_fail++;
      $display("[TB] FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule